// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block gathers event requests from a group of up to 32 sources, typically the pins of one GPIO bank, and folds them into a single level interrupt toward the processor. Every source owns a sticky pending flag. A one-cycle detect pulse sets the flag, and it stays set until software writes a one to that bit in the pending register.

Each source also has an enable flag. Software never writes the enable word directly. It turns enables on through one register and off through another, and each takes a bitmap of ones. A read-only register shows the pending flags masked by the enables. A single group enable bit decides whether the OR of those masked bits reaches the interrupt output.

Software reaches the block over a simple register bus. A write takes effect on the clock edge where the bus is valid and the write strobe is high. Read data is combinational from the address. The register selects are: 0 pending (reads the flags, write-one-to-clear), 1 enable set, 2 enable clear, 3 masked result, 4 group control (bit 0 is the group enable).

Top module: `gpio_irq_aggr`

## Requirements
- R1: After reset, the pending flags, the enable flags and the group enable are all zero, every register reads zero, and irq_o is low.
- R2: A one on bit n of src_pulse_i sets pending flag n at the next clock edge. The flag stays set over later cycles until software clears it.
- R3: A write to select 0 clears every pending flag whose write-data bit is one. Flags whose write-data bit is zero are left unchanged.
- R4: If a detect pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A write to select 1 sets every enable flag whose write-data bit is one and leaves the other enables unchanged. Selects 1 and 2 both read back the enable flags.
- R6: A write to select 2 clears every enable flag whose write-data bit is one and leaves the other enables unchanged.
- R7: Select 3 reads the pending flags ANDed with the enable flags. Writes to select 3 change no state.
- R8: irq_o is high exactly when the group enable is one and at least one source is both pending and enabled.
- R9: Writing select 4 loads the group enable from write-data bit 0. Select 4 reads the group enable in bit 0 and zero in every other bit.
- R10: A flag that goes pending while its source is disabled does not raise irq_o. If software clears the flag before enabling the source, the event is dropped and irq_o stays low after the enable.
- R11: Selects 5 to 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pulse_i | input | NUM_SRC | Per-source detect pulse |
| bus_valid_i | input | 1 | Bus access valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register, combinational |
| irq_o | output | 1 | Aggregated interrupt level |

## Verification
The hardest case to reach from the ports is a detect pulse landing on a flag in the same cycle that software writes a one to clear it. The case is harder still when that flag is disabled, so that only the pending register can show the outcome.

Directed sequences produce this collision, and also the clear-while-disabled-then-enable order. A long run of random traffic follows, with sparse pulses and random selects and data, which keeps producing collisions and enable toggles while irq_o and the read data are compared with a behavioural model on every clock.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PEND   = 3'd0,
    SEL_EN_SET = 3'd1,
    SEL_EN_CLR = 3'd2,
    SEL_RESULT = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/aggr_pending.sv
module aggr_pending #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    // set beats clear so a coincident event is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            pend_q[g] <= 1'b0;
      else if (set_i[g])                      pend_q[g] <= 1'b1;
      else if (clr_we_i && clr_mask_i[g])     pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R2 R4
  pulse_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R3
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((pend_q & $past(clr_mask_i & ~set_i)) == '0));
endmodule

// File: rtl/aggr_enable.sv
module aggr_enable #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (set_we_i) en_q <= en_q | mask_i;
    else if (clr_we_i) en_q <= en_q & ~mask_i;
  end

  assign en_o = en_q;

  // R5
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_q & $past(mask_i)) == $past(mask_i)));

  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((en_q & $past(mask_i)) == '0));

  // R5 R6
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_we_i || clr_we_i) |=> $stable(en_q));
endmodule

// File: rtl/aggr_out.sv
module aggr_out #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               grp_we_i,
  input  logic               grp_wbit_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] result_o,
  output logic               grp_en_o,
  output logic               irq_o
);
  logic grp_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       grp_en_q <= 1'b0;
    else if (grp_we_i) grp_en_q <= grp_wbit_i;
  end

  assign result_o = pend_i & en_i;
  assign grp_en_o = grp_en_q;
  assign irq_o    = grp_en_q & (|result_o);

  // R8
  irq_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(pend_i & en_i)));

  // R9
  grp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_we_i |=> (grp_en_q == $past(grp_wbit_i)));
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
  import aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [2:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int unsigned SRC_W = (NUM_SRC < DATA_W) ? NUM_SRC : DATA_W;

  logic               wr;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] pend, en, result;
  logic               grp_en;

  assign wr = bus_valid_i & bus_write_i;

  always_comb begin
    wmask = '0;
    wmask[SRC_W-1:0] = bus_wdata_i[SRC_W-1:0];
  end

  aggr_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (src_pulse_i),
    .clr_we_i  (wr && (bus_addr_i == SEL_PEND)),
    .clr_mask_i(wmask),
    .pend_o    (pend)
  );

  aggr_enable #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(wr && (bus_addr_i == SEL_EN_SET)),
    .clr_we_i(wr && (bus_addr_i == SEL_EN_CLR)),
    .mask_i  (wmask),
    .en_o    (en)
  );

  aggr_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grp_we_i  (wr && (bus_addr_i == SEL_CTRL)),
    .grp_wbit_i(bus_wdata_i[0]),
    .pend_i    (pend),
    .en_i      (en),
    .result_o  (result),
    .grp_en_o  (grp_en),
    .irq_o     (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      SEL_PEND:              bus_rdata_o[SRC_W-1:0] = pend[SRC_W-1:0];
      SEL_EN_SET, SEL_EN_CLR: bus_rdata_o[SRC_W-1:0] = en[SRC_W-1:0];
      SEL_RESULT:            bus_rdata_o[SRC_W-1:0] = result[SRC_W-1:0];
      SEL_CTRL:              bus_rdata_o[0] = grp_en;
      default:               bus_rdata_o = '0;
    endcase
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !irq_o);
endmodule

// File: tb/sim_gpio_irq_aggr.sv
module sim_gpio_irq_aggr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pulse = '0;
  logic        valid = 1'b0, write = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit [31:0] m_pend = '0, m_en = '0;
  bit        m_grp = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_aggr u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_pulse_i(pulse),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(bit [2:0] a);
    case (a)
      3'd0:       return m_pend;
      3'd1, 3'd2: return m_en;
      3'd3:       return m_pend & m_en;
      3'd4:       return {31'b0, m_grp};
      default:    return '0;
    endcase
  endfunction

  function automatic string auto_tag(bit [2:0] a);
    case (a)
      3'd0:       return "R2";
      3'd1:       return "R5";
      3'd2:       return "R6";
      3'd3:       return "R7";
      3'd4:       return "R9";
      default:    return "R11";
    endcase
  endfunction

  // drive, compare the current state, then advance the model past the edge
  task automatic step(bit v, bit w, bit [2:0] a, bit [31:0] d, bit [31:0] p, string tag);
    @(negedge clk);
    valid = v; write = w; addr = a; wdata = d; pulse = p;
    #1;
    check((tag != "") ? tag : auto_tag(a), rdata, m_read(a));
    check("R8", {31'b0, irq}, {31'b0, m_grp && ((m_pend & m_en) != 0)});
    if (v && w) begin
      case (a)
        3'd0: m_pend = m_pend & ~d;
        3'd1: m_en   = m_en | d;
        3'd2: m_en   = m_en & ~d;
        3'd4: m_grp  = d[0];
        default: ;
      endcase
    end
    m_pend = m_pend | p;
  endtask

  initial begin
    #2;
    check("R1", {31'b0, irq}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < 8; a++) step(1'b1, 1'b0, 3'(a), '0, '0, "R1");

    // R2 sticky pend, R5 enables, R8 output gated by group
    step(1, 0, 3'd0, '0, 32'h8000_0011, "R2");
    step(1, 0, 3'd0, '0, '0, "R2");
    step(1, 1, 3'd1, 32'h0000_0010, '0, "R5");
    step(1, 1, 3'd4, 32'hFFFF_FFFF, '0, "R9");
    step(1, 0, 3'd4, '0, '0, "R9");
    step(1, 0, 3'd3, '0, '0, "R7");
    // R7 writes to result ignored
    step(1, 1, 3'd3, 32'hFFFF_FFFF, '0, "R7");
    step(1, 0, 3'd3, '0, '0, "R7");
    // R11 unmapped writes ignored
    step(1, 1, 3'd6, 32'hFFFF_FFFF, '0, "R11");
    step(1, 0, 3'd0, '0, '0, "R11");
    // R3 partial clear
    step(1, 1, 3'd0, 32'h0000_0011, '0, "R3");
    step(1, 0, 3'd0, '0, '0, "R3");
    // R6 selective disable
    step(1, 1, 3'd1, 32'hF000_000F, '0, "R5");
    step(1, 1, 3'd2, 32'h3000_0003, '0, "R6");
    step(1, 0, 3'd2, '0, '0, "R6");
    // R4 pulse and clear collide on bit 3
    step(1, 1, 3'd0, 32'h0000_0008, 32'h0000_0008, "R4");
    step(1, 0, 3'd0, '0, '0, "R4");
    step(1, 1, 3'd0, 32'hFFFF_FFFF, '0, "R3");
    // R10 pend while disabled, clear, then enable
    step(1, 1, 3'd2, 32'hFFFF_FFFF, 32'h0000_0020, "R10");
    step(1, 0, 3'd0, '0, '0, "R10");
    step(1, 1, 3'd0, 32'h0000_0020, '0, "R10");
    step(1, 1, 3'd1, 32'h0000_0020, '0, "R10");
    step(1, 0, 3'd3, '0, '0, "R10");

    for (int i = 0; i < 3000; i++) begin
      bit [31:0] p = $urandom & $urandom & $urandom & $urandom;
      step(1'($urandom), 1'($urandom), 3'($urandom), $urandom, p, "");
    end
    step(0, 0, 3'd0, '0, '0, "");
    summary();
  end
endmodule